// File: doc/BRIEF.md
# UART Receive Character Buffer with Flow Control

This block sits between the receive shift register of a UART channel and the host-facing register file. Each incoming character arrives with three error tags: parity, framing and break. The block stores the character and its tags together as one entry in a ring of up to 64 entries. The oldest entry appears at the holding-register output, and its tags appear in a line-status view next to a data-ready bit and a sticky overrun bit. A host read of the holding register retires that entry and brings the next one forward with its own tags.

The block raises a receive interrupt once the fill level reaches a programmable trigger. When hardware flow control is on, an active-low request-to-send or data-terminal-ready line pauses the remote transmitter if the fill reaches the trigger plus a hysteresis margin. It lets the transmitter go again once the fill drops to the trigger minus that margin. With buffering switched off, the block behaves as a one-character holding register. A buffer-clear input, or any change of mode, empties the store in one cycle.

Top module: `rx_char_buffer`

## Requirements
- R1: Characters are delivered in arrival order, and each one keeps its own 3-bit tag: bit 0 parity, bit 1 framing, bit 2 break.
- R2: `rhr_data` shows the oldest stored character. `lsr_view[4:2]` shows that character's tags (bit 2 parity, bit 3 framing, bit 4 break). Both read 0 when the store is empty. A pulse on `rhr_read` brings the next entry forward.
- R3: A character offered to a full store is dropped and sets `lsr_view[1]`. The bit stays set until a cycle with `lsr_read` and no new drop. If a drop and `lsr_read` fall in the same cycle, the bit stays set.
- R4: `lsr_view[0]` is 1 exactly when `fill_level` is nonzero, and `fill_level` equals the number of stored characters.
- R5: `rx_irq` is 1 when `fill_level` is at least the effective trigger. The effective trigger is `trig_level`, except that 0 is treated as 1 and values above 64 are treated as 64.
- R6: The pause state sets when the fill is at least min(trigger + `hyst_level`, 64). It clears when the fill is at most max(trigger − `hyst_level`, 0). Between those two levels it holds its value, and setting takes priority over clearing.
- R7: With `hwfc_en` low, both `rts_n` and `dtr_n` are 0. With `hwfc_en` high, the pause state drives `rts_n` when `fc_use_dtr` is 0 and drives `dtr_n` when it is 1; the other line stays 0.
- R8: With `fifo_en` low, the store holds one character. A second character is dropped as an overrun. The effective trigger is 1, pause sets at 1 and clears at 0.
- R9: A push and a `rhr_read` in the same cycle leave the fill unchanged when the store is not empty, and are accepted without overrun when the store is full. A `rhr_read` on an empty store has no effect.
- R10: `fifo_clr`, or any change of `fifo_en`, empties the store, clears overrun and releases the pause state, all at the next clock edge.
- R11: All outputs are registered and reflect the inputs sampled at the previous rising edge. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Empties the store in one cycle |
| fifo_en | input | 1 | 1 = 64-entry buffering, 0 = single holding register |
| rx_valid | input | 1 | Character offered by the shift register |
| rx_data | input | 8 | Received character |
| rx_tag | input | 3 | Error tags: bit 0 parity, bit 1 framing, bit 2 break |
| rhr_read | input | 1 | Host read of the holding register |
| lsr_read | input | 1 | Host read of line status, clears overrun |
| trig_level | input | 7 | Receive trigger level |
| hyst_level | input | 7 | Flow-control hysteresis margin |
| hwfc_en | input | 1 | Enables hardware flow control |
| fc_use_dtr | input | 1 | 0 = pause on rts_n, 1 = pause on dtr_n |
| rhr_data | output | 8 | Oldest character |
| lsr_view | output | 5 | {break, framing, parity, overrun, data ready} |
| rx_irq | output | 1 | Receive trigger interrupt |
| rts_n | output | 1 | Active-low request to send |
| dtr_n | output | 1 | Active-low data terminal ready |
| fill_level | output | 7 | Stored character count |

## Verification
Each output is a single register stage past the input edge. A push, a read, a clear or a change of the thresholds therefore shows up exactly one rising edge later, with no extra pipeline delay for the flow-control lines or the interrupt. The bench drives stimulus on a falling edge and advances its scoreboard after the following rising edge. It compares the outputs on the next falling edge, so every comparison lands in the first cycle where the result is due and before the next stimulus.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;
  localparam int LSR_W  = 2 + TAG_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  rx_entry_t     push_entry,
  input  logic          pop,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output rx_entry_t     head_nxt,
  output logic          drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic            full, do_pop, do_push;
  logic [CW-1:0]   left;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = single ? (cnt_q != '0) : (cnt_q == DEPTH_C);
    do_pop  = pop && (cnt_q != '0);
    do_push = push && (!full || do_pop);
    rd_nxt  = do_pop  ? bump(rd_ptr) : rd_ptr;
    wr_nxt  = do_push ? bump(wr_ptr) : wr_ptr;
    left    = cnt_q - CW'(do_pop);
    if (clr) begin
      cnt_nxt  = '0;
      head_nxt = '0;
      drop     = 1'b0;
    end else begin
      cnt_nxt = left + CW'(do_push);
      drop    = push && !do_push;
      if (cnt_nxt == '0)
        head_nxt = '0;
      else if (left == '0)
        head_nxt = push_entry;
      else
        head_nxt = mem[rd_nxt];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr)
      mem[wr_ptr] <= push_entry;
  end
endmodule

// File: rtl/rxb_level.sv
module rxb_level #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clr,
  input  logic          single,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] trig,
  input  logic [CW-1:0] hyst,
  input  logic          pause_q,
  output logic          irq_nxt,
  output logic          pause_nxt
);
  localparam int EW = CW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [EW-1:0] DEPTH_E = EW'(DEPTH);

  logic [CW-1:0] teff, hi, lo;
  logic [EW-1:0] sum;

  always_comb begin
    if (single || trig == '0) teff = CW'(1);
    else if (trig > DEPTH_C)  teff = DEPTH_C;
    else                      teff = trig;

    sum = {1'b0, teff} + {1'b0, hyst};
    if (single)              hi = CW'(1);
    else if (sum > DEPTH_E)  hi = DEPTH_C;
    else                     hi = sum[CW-1:0];

    if (single || hyst >= teff) lo = '0;
    else                        lo = teff - hyst;

    irq_nxt = (cnt_nxt >= teff);

    if (clr)                pause_nxt = 1'b0;
    else if (cnt_nxt >= hi) pause_nxt = 1'b1;
    else if (cnt_nxt <= lo) pause_nxt = 1'b0;
    else                    pause_nxt = pause_q;
  end
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_clr,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic              rhr_read,
  input  logic              lsr_read,
  input  logic [CW-1:0]     trig_level,
  input  logic [CW-1:0]     hyst_level,
  input  logic              hwfc_en,
  input  logic              fc_use_dtr,
  output logic [DATA_W-1:0] rhr_data,
  output logic [LSR_W-1:0]  lsr_view,
  output logic              rx_irq,
  output logic              rts_n,
  output logic              dtr_n,
  output logic [CW-1:0]     fill_level
);
  logic          mode_q, clr_now, single;
  logic          ovr_q, ovr_nxt, pause_q, pause_nxt, irq_nxt, drop;
  logic [CW-1:0] cnt_q, cnt_nxt;
  rx_entry_t     in_entry, head_nxt;

  assign clr_now  = fifo_clr || (fifo_en != mode_q);
  assign single   = !fifo_en;
  assign in_entry = '{tag: rx_tag, data: rx_data};

  rxb_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_now),
    .single     (single),
    .push       (rx_valid),
    .push_entry (in_entry),
    .pop        (rhr_read),
    .cnt_q      (cnt_q),
    .cnt_nxt    (cnt_nxt),
    .head_nxt   (head_nxt),
    .drop       (drop)
  );

  rxb_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clr       (clr_now),
    .single    (single),
    .cnt_nxt   (cnt_nxt),
    .trig      (trig_level),
    .hyst      (hyst_level),
    .pause_q   (pause_q),
    .irq_nxt   (irq_nxt),
    .pause_nxt (pause_nxt)
  );

  always_comb begin
    if (clr_now)       ovr_nxt = 1'b0;
    else if (drop)     ovr_nxt = 1'b1;
    else if (lsr_read) ovr_nxt = 1'b0;
    else               ovr_nxt = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= fifo_en;
      ovr_q      <= 1'b0;
      pause_q    <= 1'b0;
      rhr_data   <= '0;
      lsr_view   <= '0;
      rx_irq     <= 1'b0;
      rts_n      <= 1'b0;
      dtr_n      <= 1'b0;
      fill_level <= '0;
    end else begin
      mode_q     <= fifo_en;
      ovr_q      <= ovr_nxt;
      pause_q    <= pause_nxt;
      rhr_data   <= head_nxt.data;
      lsr_view   <= {head_nxt.tag, ovr_nxt, cnt_nxt != '0};
      rx_irq     <= irq_nxt;
      rts_n      <= hwfc_en && !fc_use_dtr && pause_nxt;
      dtr_n      <= hwfc_en && fc_use_dtr && pause_nxt;
      fill_level <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_clr,
  input logic          fifo_en,
  input logic          rx_valid,
  input logic          rhr_read,
  input logic          lsr_read,
  input logic          hwfc_en,
  input logic [4:0]    lsr_view,
  input logic          rx_irq,
  input logic          rts_n,
  input logic          dtr_n,
  input logic [CW-1:0] fill_level
);
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(fill_level) <= DEPTH);

  p_ready_match_r4: assert property (@(posedge clk) disable iff (rst)
    lsr_view[0] == (fill_level != '0));

  p_irq_needs_data_r5: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> lsr_view[0]);

  p_single_line_r7: assert property (@(posedge clk) disable iff (rst)
    !(rts_n && dtr_n));

  p_fc_off_r7: assert property (@(posedge clk) disable iff (rst)
    !hwfc_en |=> (!rts_n && !dtr_n));

  p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
    (!fifo_clr && fifo_en == $past(fifo_en)) |=>
      int'(fill_level) <= int'($past(fill_level)) + 1);

  p_overrun_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rhr_read && !fifo_clr && fifo_en && $past(fifo_en) &&
     int'(fill_level) == DEPTH) |=> (lsr_view[1] && int'(fill_level) == DEPTH));

  p_ovr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (lsr_read && !rx_valid) |=> !lsr_view[1]);

  p_single_cap_r8: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> int'(fill_level) <= 1);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (fill_level == '0 && !lsr_view[1] && !rts_n && !dtr_n));
endmodule

bind rx_char_buffer rxb_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_clr   (fifo_clr),
  .fifo_en    (fifo_en),
  .rx_valid   (rx_valid),
  .rhr_read   (rhr_read),
  .lsr_read   (lsr_read),
  .hwfc_en    (hwfc_en),
  .lsr_view   (lsr_view),
  .rx_irq     (rx_irq),
  .rts_n      (rts_n),
  .dtr_n      (dtr_n),
  .fill_level (fill_level)
);

// File: tb/rx_char_buffer_tb.sv
`timescale 1ns/1ps
module rx_char_buffer_tb;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_clr = 0, fifo_en = 1, rx_valid = 0, rhr_read = 0, lsr_read = 0;
  logic [7:0] rx_data = '0;
  logic [2:0] rx_tag = '0;
  logic [CW-1:0] trig_level = CW'(48), hyst_level = CW'(8);
  logic hwfc_en = 1, fc_use_dtr = 0;
  logic [7:0] rhr_data;
  logic [4:0] lsr_view;
  logic rx_irq, rts_n, dtr_n;
  logic [CW-1:0] fill_level;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [10:0] sb_q[$];
  bit m_ovr = 0, m_pause = 0, m_en_prev = 1;

  always #2 clk = ~clk;

  rx_char_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .fifo_en(fifo_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_tag(rx_tag),
    .rhr_read(rhr_read), .lsr_read(lsr_read), .trig_level(trig_level),
    .hyst_level(hyst_level), .hwfc_en(hwfc_en), .fc_use_dtr(fc_use_dtr),
    .rhr_data(rhr_data), .lsr_view(lsr_view), .rx_irq(rx_irq),
    .rts_n(rts_n), .dtr_n(dtr_n), .fill_level(fill_level)
  );

  task automatic chk(string tg, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tg, nm, act, exp);
    end
  endtask

  // scoreboard update: applies the stimulus sampled at the last rising edge
  task automatic model_update(bit p, logic [10:0] ent, bit rd, bit lr, bit clr);
    int cap, teff, hi, lo, left;
    bit popped, acc;
    if (clr || fifo_en != m_en_prev) begin
      sb_q.delete();
      m_ovr = 0;
      m_pause = 0;
    end else begin
      cap = fifo_en ? DEPTH : 1;
      popped = rd && sb_q.size() > 0;
      left = sb_q.size() - (popped ? 1 : 0);
      acc = p && left < cap;
      if (popped) void'(sb_q.pop_front());
      if (acc) sb_q.push_back(ent);
      if (p && !acc) m_ovr = 1;
      else if (lr) m_ovr = 0;
      if (!fifo_en) begin teff = 1; hi = 1; lo = 0; end
      else begin
        teff = (trig_level == 0) ? 1 : (int'(trig_level) > DEPTH ? DEPTH : int'(trig_level));
        hi = teff + int'(hyst_level); if (hi > DEPTH) hi = DEPTH;
        lo = teff - int'(hyst_level); if (lo < 0) lo = 0;
      end
      if (sb_q.size() >= hi) m_pause = 1;
      else if (sb_q.size() <= lo) m_pause = 0;
    end
    m_en_prev = fifo_en;
  endtask

  // monitor: compare outputs with the scoreboard head and levels
  task automatic compare(string tg);
    int teff, n;
    n = sb_q.size();
    teff = !fifo_en ? 1 : ((trig_level == 0) ? 1 :
           (int'(trig_level) > DEPTH ? DEPTH : int'(trig_level)));
    chk(tg, "rhr_data", int'(rhr_data), n > 0 ? int'(sb_q[0][7:0]) : 0);
    chk(tg, "lsr_tags", int'(lsr_view[4:2]), n > 0 ? int'(sb_q[0][10:8]) : 0);
    chk(tg, "overrun", int'(lsr_view[1]), int'(m_ovr));
    chk({tg, "/R4"}, "data_ready", int'(lsr_view[0]), n > 0 ? 1 : 0);
    chk({tg, "/R4"}, "fill", int'(fill_level), n);
    chk(tg, "irq", int'(rx_irq), n >= teff ? 1 : 0);
    chk(tg, "rts_n", int'(rts_n), int'(hwfc_en && !fc_use_dtr && m_pause));
    chk(tg, "dtr_n", int'(dtr_n), int'(hwfc_en && fc_use_dtr && m_pause));
  endtask

  // driver: set inputs on the falling edge, one edge, check on next falling edge
  task automatic step(bit p, logic [7:0] d, logic [2:0] t, bit rd, bit lr, bit clr, string tg);
    rx_valid = p; rx_data = d; rx_tag = t; rhr_read = rd; lsr_read = lr; fifo_clr = clr;
    @(posedge clk);
    model_update(p, {t, d}, rd, lr, clr);
    @(negedge clk);
    rx_valid = 0; rhr_read = 0; lsr_read = 0; fifo_clr = 0;
    compare(tg);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_en_prev = fifo_en;
    compare("R11");

    // R1/R2: order and tags
    step(1, 8'hA5, 3'b001, 0, 0, 0, "R1");
    step(1, 8'h3C, 3'b010, 0, 0, 0, "R1");
    step(1, 8'h7E, 3'b100, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 8'h00, 3'b000, 1, 0, 0, "R2");
    step(0, 8'h00, 3'b000, 1, 0, 0, "R9");   // read on empty ignored
    step(1, 8'h11, 3'b011, 1, 0, 0, "R9");   // push+read on empty
    step(1, 8'h22, 3'b101, 1, 0, 0, "R9");   // push+read, fill stays 1
    step(0, 8'h00, 3'b000, 1, 0, 0, "R2");

    // R5/R6: fill to the top
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i * 7 + 3), 3'(i), 0, 0, 0, (i < 50) ? "R5" : "R6");
    step(1, 8'hEE, 3'b111, 0, 0, 0, "R3");   // dropped
    step(1, 8'hEF, 3'b111, 0, 1, 0, "R3");   // drop wins over status read
    step(0, 8'h00, 3'b000, 0, 1, 0, "R3");   // cleared
    step(1, 8'h99, 3'b010, 1, 0, 0, "R9");   // push+read when full
    chk("R9", "no_overrun", int'(lsr_view[1]), 0);

    // R6: drain through the release point
    for (int i = 0; i < 26; i++) step(0, 8'h00, 3'b000, 1, 0, 0, "R6");

    // R7: line selection
    fc_use_dtr = 1;
    for (int i = 0; i < 20; i++) step(1, 8'(i + 100), 3'b000, 0, 0, 0, "R7");
    hwfc_en = 0;
    step(0, 8'h00, 3'b000, 0, 0, 0, "R7");
    hwfc_en = 1;
    step(0, 8'h00, 3'b000, 0, 0, 0, "R7");

    // R10: clear input and mode change
    step(1, 8'h44, 3'b001, 0, 0, 1, "R10");
    step(1, 8'h55, 3'b001, 0, 0, 0, "R10");
    step(1, 8'h66, 3'b010, 0, 0, 0, "R10");
    fifo_en = 0;
    step(0, 8'h00, 3'b000, 0, 0, 0, "R10");

    // R8: single holding register
    step(1, 8'h81, 3'b100, 0, 0, 0, "R8");
    step(1, 8'h82, 3'b001, 0, 0, 0, "R8");
    step(0, 8'h00, 3'b000, 1, 1, 0, "R8");
    step(1, 8'h83, 3'b010, 0, 0, 0, "R8");
    step(1, 8'h84, 3'b011, 1, 0, 0, "R8");
    step(0, 8'h00, 3'b000, 1, 0, 0, "R8");

    // R6 clamp: high limit capped at 64, low limit floored at 0
    fifo_en = 1; trig_level = CW'(60); hyst_level = CW'(10); fc_use_dtr = 0;
    step(0, 8'h00, 3'b000, 0, 0, 0, "R10");
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 3'(i + 1), 0, 0, 0, "R6");
    trig_level = CW'(4);
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 3'b000, 1, 0, 0, "R6");

    // R5: trigger 0 treated as 1
    trig_level = '0; hyst_level = '0;
    step(1, 8'h5A, 3'b000, 0, 0, 0, "R5");
    step(0, 8'h00, 3'b000, 1, 0, 0, "R5");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule